// File: doc/BRIEF.md
# Split-Operand Wide Signed Multiplier

This block multiplies an 18-bit two's-complement operand by a 42-bit two's-complement operand and returns the full 60-bit signed product. It never forms one wide multiply. The wide operand is cut at bit 17 into two slices. The 17 least significant bits form an unsigned slice. Everything above them forms a 25-bit signed slice, which is the operand shifted arithmetically right by 17. Each slice is multiplied by the narrow operand in a multiplier small enough for one dedicated hardware multiply slice. The product of the upper slice is then moved up 17 places and added to the product of the lower slice.

The datapath has three register stages: captured operands, the two registered partial products, and the registered sum. A valid strobe runs alongside the data through a matching three-stage shift register. The block accepts a new operand pair on every clock and returns each result exactly three clocks later. A synchronous active-high reset clears only the valid pipeline. Any result still in flight when reset is applied is dropped. The design has no state machine. Its only control state is the valid shift register, which has two transitions: on each clock it advances one place, and on reset it clears.

Top module: `wide_split_mult`

## Requirements
- R1: For every accepted pair, the output is the exact signed product of the two operands. The narrow operand is bits [17:0] and the wide operand is bits [41:0], both two's complement, and the result is a 60-bit two's-complement value.
- R2: A pair presented with `in_valid` high at a rising clock edge appears on `out_p`, with `out_valid` high, after the third rising edge counted from that one.
- R3: Pairs may be presented on consecutive clocks. Each one yields its own result, in order, also on consecutive clocks.
- R4: Bits [16:0] of the wide operand are treated as an unsigned quantity. The product is correct when these bits are all ones, whatever the sign of either operand.
- R5: Bits [41:17] of the wide operand are treated as a signed quantity of weight 2^17. Negative wide operands give correct products.
- R6: The extreme operand values give exact products, including (-2^17) x (-2^41) = +2^58 and (2^17-1) x (2^41-1).
- R7: While reset is high, and on the first clock after it, `out_valid` is low. Results in flight when reset is applied never appear.
- R8: `out_valid` is high only for clocks that correspond to an accepted pair. Idle input clocks produce idle output clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this clock |
| in_a | input | 18 | Narrow operand, two's complement |
| in_b | input | 42 | Wide operand, two's complement |
| out_valid | output | 1 | Result present this clock |
| out_p | output | 60 | Signed product |

## Verification
Two functions can fall in the same clock. A result can emerge while a new pair is being accepted, and a reset can land while results are still in flight. The first case is provoked by unbroken back-to-back streams and by random bursts with gaps, and it is judged by matching every result, in order and at its due clock, against a queue of full-width reference products. The second case is provoked by raising reset one clock after two pairs enter. It is judged by requiring `out_valid` to stay low from then on, although one of those results would otherwise have surfaced on the very clock the reset takes effect.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
    localparam int WSM_A_W   = 18;
    localparam int WSM_B_W   = 42;
    localparam int WSM_SPLIT = 17;
    localparam int WSM_LAT   = 3;
endpackage

// File: rtl/wsm_split.sv
module wsm_split #(
    parameter int A_W   = 18,
    parameter int B_W   = 42,
    parameter int SPLIT = 17,
    localparam int HI_W = B_W - SPLIT
) (
    input  logic             clk,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic [A_W-1:0]   a_q,
    output logic [SPLIT-1:0] lo_q,
    output logic [HI_W-1:0]  hi_q
);
    // operand capture; data registers carry no reset
    always_ff @(posedge clk) begin
        a_q  <= a_in;
        lo_q <= b_in[SPLIT-1:0];
        hi_q <= b_in[B_W-1:SPLIT];
    end
endmodule

// File: rtl/wsm_pmul.sv
module wsm_pmul #(
    parameter int XW = 18,
    parameter int YW = 17,
    parameter bit Y_UNSIGNED = 1'b1,
    localparam int PW = XW + YW + (Y_UNSIGNED ? 1 : 0)
) (
    input  logic          clk,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic [PW-1:0] p_q
);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ye;
    logic signed [PW-1:0] prod;

    assign xe = PW'($signed(x));

    generate
        if (Y_UNSIGNED) begin : g_zext
            assign ye = PW'($signed({1'b0, y}));
        end else begin : g_sext
            assign ye = PW'($signed(y));
        end
    endgenerate

    assign prod = xe * ye;

    always_ff @(posedge clk) begin
        p_q <= prod;
    end
endmodule

// File: rtl/wsm_sum.sv
module wsm_sum #(
    parameter int P0_W  = 36,
    parameter int P1_W  = 43,
    parameter int SPLIT = 17,
    parameter int P_W   = 60
) (
    input  logic            clk,
    input  logic [P0_W-1:0] pp_lo,
    input  logic [P1_W-1:0] pp_hi,
    output logic [P_W-1:0]  sum_q
);
    logic signed [P_W-1:0] lo_ext;
    logic signed [P_W-1:0] hi_ext;
    logic signed [P_W-1:0] total;

    assign lo_ext = P_W'($signed(pp_lo));
    assign hi_ext = P_W'($signed(pp_hi));
    assign total  = lo_ext + (hi_ext <<< SPLIT);

    always_ff @(posedge clk) begin
        sum_q <= total;
    end
endmodule

// File: rtl/wsm_vpipe.sv
module wsm_vpipe #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             v_in,
    output logic [DEPTH-1:0] v_q
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) v_q[i] <= 1'b0;
                    else     v_q[i] <= v_in;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) v_q[i] <= 1'b0;
                    else     v_q[i] <= v_q[i-1];
                end
            end
        end
    endgenerate

    AST_RESET_CLEARS_PIPE: assert property (@(posedge clk) $past(rst) |-> (v_q == '0)); // R7
endmodule

// File: rtl/wide_split_mult.sv
module wide_split_mult #(
    parameter int A_W   = wsm_pkg::WSM_A_W,
    parameter int B_W   = wsm_pkg::WSM_B_W,
    parameter int SPLIT = wsm_pkg::WSM_SPLIT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [A_W-1:0]       in_a,
    input  logic [B_W-1:0]       in_b,
    output logic                 out_valid,
    output logic [A_W+B_W-1:0]   out_p
);
    localparam int LAT  = wsm_pkg::WSM_LAT;
    localparam int HI_W = B_W - SPLIT;
    localparam int P_W  = A_W + B_W;
    localparam int P0_W = A_W + SPLIT + 1;
    localparam int P1_W = A_W + HI_W;

    logic [A_W-1:0]   a_q;
    logic [SPLIT-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;
    logic [P0_W-1:0]  pp0_q;
    logic [P1_W-1:0]  pp1_q;
    logic [LAT-1:0]   vld;

    wsm_split #(.A_W(A_W), .B_W(B_W), .SPLIT(SPLIT)) u_split (
        .clk(clk), .a_in(in_a), .b_in(in_b),
        .a_q(a_q), .lo_q(lo_q), .hi_q(hi_q)
    );

    wsm_pmul #(.XW(A_W), .YW(SPLIT), .Y_UNSIGNED(1'b1)) u_mul_lo (
        .clk(clk), .x(a_q), .y(lo_q), .p_q(pp0_q)
    );

    wsm_pmul #(.XW(A_W), .YW(HI_W), .Y_UNSIGNED(1'b0)) u_mul_hi (
        .clk(clk), .x(a_q), .y(hi_q), .p_q(pp1_q)
    );

    wsm_sum #(.P0_W(P0_W), .P1_W(P1_W), .SPLIT(SPLIT), .P_W(P_W)) u_sum (
        .clk(clk), .pp_lo(pp0_q), .pp_hi(pp1_q), .sum_q(out_p)
    );

    wsm_vpipe #(.DEPTH(LAT)) u_vpipe (
        .clk(clk), .rst(rst), .v_in(in_valid), .v_q(vld)
    );

    assign out_valid = vld[LAT-1];

    // full-width reference product used only by the checks below
    logic signed [P_W-1:0] ref_full;
    assign ref_full = P_W'($signed(in_a)) * P_W'($signed(in_b));

    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_p == $past(ref_full, 3))); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##2 out_valid); // R2
    AST_LOW_SLICE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (vld[1] && pp0_q[P0_W-1]) |-> $past(a_q[A_W-1])); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3)); // R8
endmodule

// File: tb/wide_split_mult_bench.sv
module wide_split_mult_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [17:0] in_a;
    logic [41:0] in_b;
    logic        out_valid;
    logic [59:0] out_p;

    always #10 clk = ~clk;

    wide_split_mult u_wide_split_mult (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_p(out_p)
    );

    typedef struct {
        logic [59:0] prod;
        int          due;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [59:0] ref_mul(logic [17:0] x, logic [41:0] y);
        logic signed [59:0] xs;
        logic signed [59:0] ys;
        xs = {{42{x[17]}}, x};
        ys = {{18{y[41]}}, y};
        return xs * ys;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic send(logic [17:0] x, logic [41:0] y, string tag);
        item_t it;
        it.prod = ref_mul(x, y);
        it.due  = cyc + 3;
        it.tag  = tag;
        sb.push_back(it);
        in_a = x;
        in_b = y;
        in_valid = 1'b1;
        @(posedge clk);
        #5;
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && !ended && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "result with no accepted pair", 64'(out_valid), 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(out_p == it.prod, it.tag, "product", 64'(out_p), 64'(it.prod));
                chk(cyc == it.due, "R2", "result clock", 64'(cyc), 64'(it.due));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R2", "watchdog expired", 64'(cyc), 64'd0);
        finish_run();
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_a = '0;
        in_b = '0;
        repeat (3) @(posedge clk);
        #5;
        chk(out_valid == 1'b0, "R7", "out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(posedge clk);
        #5;
        chk(out_valid == 1'b0, "R7", "out_valid after reset", 64'(out_valid), 64'd0);

        // simple values
        send(18'd3, 42'd5, "R1");
        send(18'h3FFFF, 42'd7, "R1");
        idle(4);

        // R4: low 17 bits all ones
        send(18'd12345, 42'h0001FFFF, "R4");
        send(18'h3FFFF, 42'h3FFFFFFFFFF, "R4");
        send(18'h20000, 42'h15A5A41FFFF, "R4");
        // R5: negative wide operands
        send(18'd777, 42'h3FFFFFE0000, "R5");
        send(18'h1ABCD, 42'h20000000001, "R5");
        // R6: extremes
        send(18'h20000, 42'h20000000000, "R6");
        send(18'h1FFFF, 42'h1FFFFFFFFFF, "R6");
        send(18'h20000, 42'h1FFFFFFFFFF, "R6");
        send(18'h1FFFF, 42'h20000000000, "R6");
        idle(5);
        chk(sb.size() == 0, "R3", "back-to-back drain", 64'(sb.size()), 64'd0);

        // R3: long unbroken stream
        for (int i = 0; i < 40; i++) begin
            send(18'($urandom), {10'($urandom), 32'($urandom)}, "R3");
        end
        idle(5);
        chk(sb.size() == 0, "R3", "stream drain", 64'(sb.size()), 64'd0);

        // R1/R8: random bursts with gaps
        for (int i = 0; i < 200; i++) begin
            send(18'($urandom), {10'($urandom), 32'($urandom)}, "R1");
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        end
        idle(5);
        chk(sb.size() == 0, "R8", "burst drain", 64'(sb.size()), 64'd0);

        // R7: reset with results in flight
        send(18'd11, 42'd13, "R7");
        send(18'd17, 42'd19, "R7");
        rst = 1'b1;
        sb.delete();
        @(posedge clk);
        #5;
        chk(out_valid == 1'b0, "R7", "flush clock", 64'(out_valid), 64'd0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #5;
            chk(out_valid == 1'b0, "R7", "dropped result reappeared", 64'(out_valid), 64'd0);
        end

        // pipeline works again after reset
        send(18'h2AAAA, 42'h2AAAAAAAAAA, "R1");
        idle(5);
        chk(sb.size() == 0, "R1", "final drain", 64'(sb.size()), 64'd0);
        finish_run();
    end
endmodule